// File: doc/BRIEF.md
# External Bus Arbiter with Error Monitor

This block hands one shared external bus to one of three requesting masters and watches every access it grants. Master 0 is the external DMA engine, master 1 is the secondary internal bus that carries the other bus masters, and master 2 is the processor's internal bus. When the bus is idle and several masters are waiting, the lowest-numbered one wins. A grant is held until that access ends, either normally or with an error. A higher-priority request never cuts a running transfer short.

Each granted access is checked before it reaches the external side. The upper four address bits select an area. Areas 0 to 8 are mapped, where 0 to 7 are the chip-select areas and 8 is the SDRAM area. Areas 9 to 15 are unmapped. A nine-bit disable mask can switch off any mapped area. Faulty accesses are never passed outward. Accesses that stay unacknowledged too long are aborted.

The first error is latched into status outputs together with its master and address. It raises a level interrupt that holds until a clear pulse.

Top module: `xbus_arb_mon`

## Requirements
- R1: After reset every grant, response, `ext_req_o` and `irq_o` is low, and `err_code_o` is 0.
- R2: Requests that wait together while the bus is idle are granted in the order master 0, then 1, then 2. The grant appears in the cycle after the request is first seen, and at most one grant is high at a time.
- R3: A grant stays unchanged while its access is running, whatever other requests arrive. After every completion or abort there is one cycle with no grant before the next grant.
- R4: While a legal access is granted, `ext_ack_i` high makes `mst_done_o` of the owner high in that same cycle, and the grant drops at the next edge.
- R5: An access whose area field `addr[15:12]` is 9 or more is answered with `mst_err_o` in its first granted cycle, with `ext_req_o` low. It is recorded with code 1.
- R6: An access to a mapped area whose bit in `area_dis_i` is 1 is answered with `mst_err_o` in its first granted cycle, with `ext_req_o` low. It is recorded with code 2.
- R7: An access not acknowledged by its 768th granted cycle is answered with `mst_err_o` in that cycle and recorded with code 3. The cycle count restarts at every new grant.
- R8: Any error sets `irq_o` at the next edge. `irq_o` and the status stay unchanged until `err_clr_i` is pulsed. While status is pending, later errors are not recorded.
- R9: The recorded status carries the offending master number in `err_mid_o` and its full address in `err_addr_o`. Clearing returns the code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mst_req_i | input | 3 | Request with valid address, one bit per master |
| mst_addr_i | input | 48 | Addresses, master m in bits [16m+15:16m] |
| mst_gnt_o | output | 3 | Grant, one-hot or zero |
| mst_done_o | output | 3 | Normal completion for the owner |
| mst_err_o | output | 3 | Error termination for the owner |
| area_dis_i | input | 9 | Per-area disable mask |
| ext_req_o | output | 1 | Legal access in progress on the external side |
| ext_addr_o | output | 16 | Address of the granted access |
| ext_mid_o | output | 2 | Number of the granted master |
| ext_ack_i | input | 1 | Completion from the external side |
| irq_o | output | 1 | Level error interrupt |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the status |
| err_code_o | output | 2 | 0 none, 1 unmapped, 2 disabled, 3 timeout |
| err_mid_o | output | 2 | Master number of the recorded error |
| err_addr_o | output | 16 | Address of the recorded error |

## Verification
The hardest situation to reach from the ports is the timeout boundary. It needs a grant held exactly 768 cycles with no acknowledge. It also needs a proof that the count restarts, which takes a grant that finishes late followed by one that runs out. The stimulus acknowledges one access just before the limit and then leaves the next one unanswered, counting sampled cycles from the first granted cycle. Status retention is reached by provoking a second error of a different kind while the first is still pending. The areas are swept completely for every master under a fixed mask, with the expected error code computed in the bench.

// File: rtl/xbus_arb_pkg.sv
package xbus_arb_pkg;

   typedef enum logic [1:0] {
      ERR_NONE     = 2'd0,
      ERR_UNMAPPED = 2'd1,
      ERR_AREA_OFF = 2'd2,
      ERR_TIMEOUT  = 2'd3
   } xbus_err_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } xbus_state_e;

endpackage

// File: rtl/xbus_prio_pick.sv
module xbus_prio_pick #(
   parameter int N   = 3,
   localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]   req_i,
   output logic [N-1:0]   win_o,
   output logic [IDW-1:0] win_id_o,
   output logic           any_o
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign seen[i+1] = seen[i] | req_i[i];
      assign win_o[i]  = req_i[i] & ~seen[i];
   end

   assign any_o = seen[N];

   always_comb begin
      win_id_o = '0;
      for (int i = 0; i < N; i++) begin
         if (win_o[i]) win_id_o = IDW'(i);
      end
   end

endmodule

// File: rtl/xbus_area_chk.sv
module xbus_area_chk #(
   parameter int AW     = 16,
   parameter int SEL_W  = 4,
   parameter int N_AREA = 9
) (
   input  logic [AW-1:0]     addr_i,
   input  logic [N_AREA-1:0] dis_i,
   output logic              unmapped_o,
   output logic              area_off_o
);

   localparam int SLOTS = 1 << SEL_W;

   logic [SEL_W-1:0] area;
   logic [SLOTS-1:0] dis_pad;

   assign area = addr_i[AW-1 -: SEL_W];

   if (SLOTS > N_AREA) begin : g_pad
      assign dis_pad = {{(SLOTS-N_AREA){1'b0}}, dis_i};
   end else begin : g_full
      assign dis_pad = dis_i;
   end

   assign unmapped_o = (int'(area) >= N_AREA);
   assign area_off_o = ~unmapped_o & dis_pad[area];

endmodule

// File: rtl/xbus_err_status.sv
module xbus_err_status #(
   parameter int IDW = 2,
   parameter int AW  = 16
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   ev_i,
   input  xbus_arb_pkg::xbus_err_e code_i,
   input  logic [IDW-1:0]         mid_i,
   input  logic [AW-1:0]          addr_i,
   input  logic                   clr_i,
   output logic                   irq_o,
   output logic [1:0]             code_o,
   output logic [IDW-1:0]         mid_o,
   output logic [AW-1:0]          addr_o
);

   import xbus_arb_pkg::*;

   logic     pend_q;
   xbus_err_e code_q;
   logic [IDW-1:0] mid_q;
   logic [AW-1:0]  addr_q;
   logic           take;

   assign take = ev_i & (~pend_q | clr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         code_q <= ERR_NONE;
         mid_q  <= '0;
         addr_q <= '0;
      end else if (take) begin
         pend_q <= 1'b1;
         code_q <= code_i;
         mid_q  <= mid_i;
         addr_q <= addr_i;
      end else if (clr_i) begin
         pend_q <= 1'b0;
         code_q <= ERR_NONE;
         mid_q  <= '0;
         addr_q <= '0;
      end
   end

   assign irq_o  = pend_q;
   assign code_o = code_q;
   assign mid_o  = mid_q;
   assign addr_o = addr_q;

endmodule

// File: rtl/xbus_arb_mon.sv
module xbus_arb_mon #(
   parameter int N_MST       = 3,
   parameter int AW          = 16,
   parameter int SEL_W       = 4,
   parameter int N_AREA      = 9,
   parameter int TIMEOUT_CYC = 768,
   localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1,
   localparam int CW  = $clog2(TIMEOUT_CYC)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [N_MST-1:0]     mst_req_i,
   input  logic [N_MST*AW-1:0]  mst_addr_i,
   output logic [N_MST-1:0]     mst_gnt_o,
   output logic [N_MST-1:0]     mst_done_o,
   output logic [N_MST-1:0]     mst_err_o,
   input  logic [N_AREA-1:0]    area_dis_i,
   output logic                 ext_req_o,
   output logic [AW-1:0]        ext_addr_o,
   output logic [IDW-1:0]       ext_mid_o,
   input  logic                 ext_ack_i,
   output logic                 irq_o,
   input  logic                 err_clr_i,
   output logic [1:0]           err_code_o,
   output logic [IDW-1:0]       err_mid_o,
   output logic [AW-1:0]        err_addr_o
);

   import xbus_arb_pkg::*;

   if (N_MST < 2) begin : g_bad_mst
      $error("xbus_arb_mon: N_MST must be at least 2");
   end
   if (N_AREA > (1 << SEL_W)) begin : g_bad_area
      $error("xbus_arb_mon: N_AREA exceeds the area field");
   end
   if (SEL_W > AW) begin : g_bad_sel
      $error("xbus_arb_mon: SEL_W wider than the address");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("xbus_arb_mon: TIMEOUT_CYC too small");
   end

   xbus_state_e        state_q;
   logic [N_MST-1:0]   gnt_q;
   logic [IDW-1:0]     owner_q;
   logic [CW-1:0]      tmo_q;

   logic [N_MST-1:0]   win;
   logic [IDW-1:0]     win_id;
   logic               any_req;
   logic [AW-1:0]      cur_addr;
   logic               unmapped, area_off, fault;
   logic               busy, tmo_hit, fin_ok, fin_err;
   xbus_err_e          ev_code;

   xbus_prio_pick #(.N(N_MST)) u_pick (
      .req_i    (mst_req_i),
      .win_o    (win),
      .win_id_o (win_id),
      .any_o    (any_req)
   );

   always_comb begin
      cur_addr = '0;
      for (int i = 0; i < N_MST; i++) begin
         if (gnt_q[i]) cur_addr = mst_addr_i[i*AW +: AW];
      end
   end

   xbus_area_chk #(.AW(AW), .SEL_W(SEL_W), .N_AREA(N_AREA)) u_area (
      .addr_i     (cur_addr),
      .dis_i      (area_dis_i),
      .unmapped_o (unmapped),
      .area_off_o (area_off)
   );

   assign busy    = (state_q == ST_BUSY);
   assign fault   = busy & (unmapped | area_off);
   assign tmo_hit = busy & ~fault & ~ext_ack_i & (tmo_q == CW'(TIMEOUT_CYC - 1));
   assign fin_ok  = busy & ~fault & ext_ack_i;
   assign fin_err = fault | tmo_hit;

   always_comb begin
      if (unmapped)      ev_code = ERR_UNMAPPED;
      else if (area_off) ev_code = ERR_AREA_OFF;
      else               ev_code = ERR_TIMEOUT;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         gnt_q   <= '0;
         owner_q <= '0;
         tmo_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (any_req) begin
                  state_q <= ST_BUSY;
                  gnt_q   <= win;
                  owner_q <= win_id;
                  tmo_q   <= '0;
               end
            end
            default: begin
               if (fin_ok || fin_err) begin
                  state_q <= ST_IDLE;
                  gnt_q   <= '0;
                  tmo_q   <= '0;
               end else begin
                  tmo_q <= tmo_q + 1'b1;
               end
            end
         endcase
      end
   end

   xbus_err_status #(.IDW(IDW), .AW(AW)) u_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (fin_err),
      .code_i (ev_code),
      .mid_i  (owner_q),
      .addr_i (cur_addr),
      .clr_i  (err_clr_i),
      .irq_o  (irq_o),
      .code_o (err_code_o),
      .mid_o  (err_mid_o),
      .addr_o (err_addr_o)
   );

   assign mst_gnt_o  = gnt_q;
   assign mst_done_o = gnt_q & {N_MST{fin_ok}};
   assign mst_err_o  = gnt_q & {N_MST{fin_err}};
   assign ext_req_o  = busy & ~fault;
   assign ext_addr_o = cur_addr;
   assign ext_mid_o  = owner_q;

endmodule

// File: rtl/xbus_arb_mon_chk.sv
module xbus_arb_mon_chk #(
   parameter int N_MST       = 3,
   parameter int TIMEOUT_CYC = 768
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_MST-1:0] mst_gnt_o,
   input logic [N_MST-1:0] mst_done_o,
   input logic [N_MST-1:0] mst_err_o,
   input logic             ext_req_o,
   input logic             ext_ack_i,
   input logic             irq_o,
   input logic             err_clr_i,
   input logic [1:0]       err_code_o
);

   localparam int GW = $clog2(TIMEOUT_CYC) + 2;

   logic [GW-1:0] gcnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          gcnt <= '0;
      else if (~|mst_gnt_o) gcnt <= '0;
      else                  gcnt <= gcnt + 1'b1;
   end

   p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(mst_gnt_o));

   p_grant_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|mst_gnt_o) && !(|mst_done_o) && !(|mst_err_o)) |=> (mst_gnt_o == $past(mst_gnt_o)));

   p_gap_after_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|mst_done_o) || (|mst_err_o)) |=> (mst_gnt_o == '0));

   p_rsp_owner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((mst_done_o | mst_err_o) & ~mst_gnt_o) == '0));

   p_ack_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_req_o && ext_ack_i) |-> (|mst_done_o));

   p_ext_needs_gnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_req_o |-> (|mst_gnt_o));

   p_timeout_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|mst_gnt_o) |-> (gcnt < GW'(TIMEOUT_CYC)));

   p_err_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|mst_err_o) |=> irq_o);

   p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !err_clr_i) |=> (irq_o && $stable(err_code_o)));

endmodule

bind xbus_arb_mon xbus_arb_mon_chk #(
   .N_MST       (N_MST),
   .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mst_gnt_o  (mst_gnt_o),
   .mst_done_o (mst_done_o),
   .mst_err_o  (mst_err_o),
   .ext_req_o  (ext_req_o),
   .ext_ack_i  (ext_ack_i),
   .irq_o      (irq_o),
   .err_clr_i  (err_clr_i),
   .err_code_o (err_code_o)
);

// File: tb/xbus_arb_mon_tb_top.sv
module xbus_arb_mon_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req = '0;
   logic [47:0] addr_v = '0;
   logic [2:0]  gnt, done, err;
   logic [8:0]  dis = 9'b1_0010_0100;
   logic        ext_req, ext_ack = 1'b0;
   logic [15:0] ext_addr;
   logic [1:0]  ext_mid;
   logic        irq, clr = 1'b0;
   logic [1:0]  code, emid;
   logic [15:0] eaddr;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   xbus_arb_mon dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .mst_req_i (req), .mst_addr_i (addr_v),
      .mst_gnt_o (gnt), .mst_done_o (done), .mst_err_o (err),
      .area_dis_i (dis),
      .ext_req_o (ext_req), .ext_addr_o (ext_addr), .ext_mid_o (ext_mid),
      .ext_ack_i (ext_ack),
      .irq_o (irq), .err_clr_i (clr),
      .err_code_o (code), .err_mid_o (emid), .err_addr_o (eaddr)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int exp_code(input int area);
      if (area >= 9) return 1;
      if (dis[area]) return 2;
      return 0;
   endfunction

   task automatic clear_status();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      #1;
      chk(irq == 1'b0, "R8 irq after clear", irq, 0);
      chk(code == 2'd0, "R9 code after clear", code, 0);
   endtask

   // One access by master m; lat cycles before ack; a pending flag tells
   // whether a prior error is still latched.
   task automatic do_acc(input int m, input logic [15:0] a, input int lat, input bit pend);
      int ec;
      bit was_pend;
      logic [1:0] old_code;
      ec = exp_code(int'(a[15:12]));
      was_pend = pend;
      old_code = code;
      @(negedge clk);
      req[m] = 1'b1;
      addr_v[m*16 +: 16] = a;
      @(negedge clk);
      chk(gnt == 3'(1 << m), "R2 single grant", gnt, 1 << m);
      if (ec != 0) begin
         chk(err[m] == 1'b1, ec == 1 ? "R5 error response" : "R6 error response", err, 1 << m);
         chk(ext_req == 1'b0, ec == 1 ? "R5 ext blocked" : "R6 ext blocked", ext_req, 0);
         req[m] = 1'b0;
         @(negedge clk);
         chk(gnt == 3'b000, "R3 gap after error", gnt, 0);
         chk(irq == 1'b1, "R8 irq set", irq, 1);
         if (!was_pend) begin
            chk(code == 2'(ec), ec == 1 ? "R5 code" : "R6 code", code, ec);
            chk(emid == 2'(m), "R9 master id", emid, m);
            chk(eaddr == a, "R9 address", eaddr, a);
         end else begin
            chk(code == old_code, "R8 first error kept", code, old_code);
         end
      end else begin
         chk(ext_req == 1'b1 && ext_addr == a && ext_mid == 2'(m), "R4 ext side", ext_addr, a);
         for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk(done == 3'b000 && gnt == 3'(1 << m), "R3 held while waiting", gnt, 1 << m);
         end
         ext_ack = 1'b1;
         req[m] = 1'b0;
         #1;
         chk(done == 3'(1 << m) && err == 3'b000, "R4 done", done, 1 << m);
         @(negedge clk);
         ext_ack = 1'b0;
         chk(gnt == 3'b000, "R4 grant dropped", gnt, 0);
      end
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(gnt == 3'b000 && done == 3'b000 && err == 3'b000, "R1 outputs", gnt, 0);
      chk(irq == 1'b0 && ext_req == 1'b0 && code == 2'd0, "R1 status", code, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R6 R9: every area, every master
      for (int m = 0; m < 3; m++) begin
         for (int ar = 0; ar < 16; ar++) begin
            do_acc(m, {4'(ar), 12'(ar * 37 + m * 5)}, ar % 3, 1'b0);
            if (exp_code(ar) != 0) clear_status();
         end
      end

      // R8: second error while pending is not recorded
      do_acc(1, 16'hA123, 0, 1'b0);
      do_acc(2, 16'h2044, 0, 1'b1);
      chk(emid == 2'd1 && eaddr == 16'hA123, "R8 status retained", eaddr, 16'hA123);
      clear_status();

      // R2 R3: all request patterns, served in priority order with gaps
      for (int pat = 1; pat < 8; pat++) begin
         int left;
         @(negedge clk);
         for (int m = 0; m < 3; m++) begin
            addr_v[m*16 +: 16] = 16'h1000 + 16'(m);
            req[m] = pat[m];
         end
         left = pat;
         while (left != 0) begin
            int w;
            w = (left & 1) ? 0 : ((left & 2) ? 1 : 2);
            @(negedge clk);
            chk(gnt == 3'(1 << w), "R2 priority winner", gnt, 1 << w);
            ext_ack = 1'b1;
            req[w] = 1'b0;
            @(negedge clk);
            ext_ack = 1'b0;
            chk(gnt == 3'b000, "R3 idle gap", gnt, 0);
            left = left & ~(1 << w);
         end
      end

      // R3: no preemption by a higher request
      @(negedge clk);
      req[2] = 1'b1;
      addr_v[32 +: 16] = 16'h3000;
      @(negedge clk);
      req[0] = 1'b1;
      addr_v[0 +: 16] = 16'h0000;
      repeat (3) begin
         @(negedge clk);
         chk(gnt == 3'b100, "R3 no preemption", gnt, 4);
      end
      ext_ack = 1'b1;
      req[2] = 1'b0;
      @(negedge clk);
      ext_ack = 1'b0;
      @(negedge clk);
      chk(gnt == 3'b001, "R3 waiting master next", gnt, 1);
      ext_ack = 1'b1;
      req[0] = 1'b0;
      @(negedge clk);
      ext_ack = 1'b0;

      // R7: late ack just before the limit, then a full timeout
      do_acc(1, 16'h4010, 766, 1'b0);
      chk(irq == 1'b0, "R7 no timeout at 767 cycles", irq, 0);
      begin
         int k;
         @(negedge clk);
         req[1] = 1'b1;
         addr_v[16 +: 16] = 16'h6ABC;
         @(negedge clk);
         k = 1;
         while (!err[1] && k < 2000) begin
            @(negedge clk);
            k++;
         end
         chk(k == 768, "R7 timeout cycle", k, 768);
         req[1] = 1'b0;
         @(negedge clk);
         chk(code == 2'd3 && irq == 1'b1, "R7 timeout code", code, 3);
         chk(emid == 2'd1 && eaddr == 16'h6ABC, "R9 timeout status", eaddr, 16'h6ABC);
         repeat (4) @(negedge clk);
         chk(irq == 1'b1, "R8 level held", irq, 1);
         clear_status();
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule